// File: doc/BRIEF.md
# Instruction Fetch Line Buffer

This block sits between an in-order fetch stage and the instruction cache. It holds a few whole instruction lines, so that neighbouring fetches are served without a new cache access. An instruction moves through it in two steps. A start request either joins a line that is already in flight or resident, or it sends one line-aligned request to the cache. A later finish request collects the 32-bit instruction word from the line.

Lines whose memory access is outstanding are kept in an in-flight list, separate from the resident lines. Every line, in flight or resident, carries a count of the instructions still waiting on it. A resident line is chosen for replacement only when nobody waits on it, and the choice is the least recently used such line. A squash port withdraws a waiting instruction. Line returns for lines that were dropped are discarded.

Top module: `ifetch_line_buf`

## Requirements
- R1: After reset both lists are empty. A finish request stalls (`cmpl_ready`=0), and the first start request to any line issues a line request.
- R2: A line is identified by address-space ID together with its line address, the PC with its low log2(LINE_BYTES) bits cleared. A line held under one ID does not serve a request carrying another ID.
- R3: A start request that finds its line in the in-flight list is accepted with `init_buf`=1. It issues no line request and adds one waiter to that entry.
- R4: When the in-flight list is not full and the line is not in flight, a start request that hits a resident line is accepted with `init_buf`=1 and issues no line request.
- R5: When the in-flight list holds NUM_LINES entries, a start request whose line is not in flight gets `init_ready`=0 and issues no line request, even if the line is resident.
- R6: A start request that misses both lists is accepted with `init_buf`=0. In the same cycle it raises `lreq_valid` with the request's ID and its line-aligned address, and it opens an in-flight entry with one waiter.
- R7: A line return whose ID and address match an in-flight entry stores the whole line. A line return that matches no in-flight entry is discarded.
- R8: A finish request with `cmpl_buf`=1 stalls while its line is not resident. Otherwise it is accepted and returns word (PC mod LINE_BYTES)/4, which is bits [32k+31:32k] of the line. It removes one waiter and makes the line most recently used.
- R9: A finish request with `cmpl_buf`=0 stalls until the line return of its in-flight entry has been stored in an earlier cycle. It then returns the word as in R8 and moves the line, less one waiter, into the resident set as most recently used.
- R10: When all resident slots are in use, the line moved in by R9 replaces the least recently used resident line that has no waiters. If every resident line has waiters, the finish request stalls.
- R11: A squash removes one waiter from its line. A resident line stays resident. An in-flight entry whose count reaches zero is dropped, so a later start request to that line issues a new line request.
- R12: Only one of squash, finish and start is served per cycle, with squash first and start last. A request that is not served sees ready=0. Line returns are taken in every cycle, in parallel with the other requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Start request present |
| init_asid | input | ASID_W | Start request address-space ID |
| init_pc | input | ADDR_W | Start request PC |
| init_ready | output | 1 | Start request accepted this cycle |
| init_buf | output | 1 | Accepted start will be served from the buffer (no line request) |
| lreq_valid | output | 1 | Line request to the cache |
| lreq_asid | output | ASID_W | Line request address-space ID |
| lreq_addr | output | ADDR_W | Line-aligned request address |
| fill_valid | input | 1 | Line return present |
| fill_asid | input | ASID_W | Line return address-space ID |
| fill_addr | input | ADDR_W | Line return address |
| fill_data | input | LINE_BYTES*8 | Whole returned line |
| cmpl_valid | input | 1 | Finish request present |
| cmpl_buf | input | 1 | Finish request was marked buffer-served at start |
| cmpl_asid | input | ASID_W | Finish request address-space ID |
| cmpl_pc | input | ADDR_W | Finish request PC |
| cmpl_ready | output | 1 | Finish request served this cycle |
| cmpl_insn | output | 32 | Instruction word, valid with cmpl_ready |
| sq_valid | input | 1 | Squash of one waiting instruction |
| sq_asid | input | ASID_W | Squashed instruction's address-space ID |
| sq_pc | input | ADDR_W | Squashed instruction's PC |

## Verification
A line return and a finish request for the same line can arrive in the same cycle. The bench drives both together and expects the finish request to stall in that cycle and be served in the next one with the returned word. A squash can also coincide with a start request, and a finish request with a start request. The bench provokes both pairs and judges them by the ready outputs. It also follows up with a start request whose outcome, a fresh line request or a buffer join, shows that the served operation changed the state and the other did not.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
  // operation granted the single update slot in a cycle
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INIT = 2'd1,
    OP_CMPL = 2'd2,
    OP_SQSH = 2'd3
  } ilb_op_e;
endpackage

// File: rtl/ilb_match.sv
module ilb_match #(
  parameter int N     = 4,
  parameter int KEY_W = 34,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       vld,
  input  logic [N*KEY_W-1:0] keys,
  input  logic [KEY_W-1:0]   key,
  output logic               hit,
  output logic [IW-1:0]      idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int j = 0; j < N; j++) begin
      if (vld[j] && keys[j*KEY_W +: KEY_W] == key && !hit) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/ilb_victim.sv
module ilb_victim #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    vld,
  input  logic [N-1:0]    idle,
  input  logic [N*IW-1:0] ages,
  output logic            free_ok,
  output logic [IW-1:0]   free_idx,
  output logic            evict_ok,
  output logic [IW-1:0]   evict_idx
);
  logic [IW-1:0] best_age;

  // lowest-numbered unused slot
  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (!vld[j]) begin
        free_ok  = 1'b1;
        free_idx = IW'(j);
      end
    end
  end

  // oldest line with no waiters (smallest age = least recent)
  always_comb begin
    evict_ok  = 1'b0;
    evict_idx = '0;
    best_age  = '1;
    for (int j = 0; j < N; j++) begin
      if (vld[j] && idle[j] && (!evict_ok || ages[j*IW +: IW] < best_age)) begin
        evict_ok  = 1'b1;
        evict_idx = IW'(j);
        best_age  = ages[j*IW +: IW];
      end
    end
  end
endmodule

// File: rtl/ifetch_line_buf.sv
module ifetch_line_buf
  import ilb_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int ASID_W     = 8,
  parameter int CNT_W      = 4,
  localparam int INSN_W    = 32,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_valid,
  input  logic [ASID_W-1:0] init_asid,
  input  logic [ADDR_W-1:0] init_pc,
  output logic              init_ready,
  output logic              init_buf,
  output logic              lreq_valid,
  output logic [ASID_W-1:0] lreq_asid,
  output logic [ADDR_W-1:0] lreq_addr,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              cmpl_valid,
  input  logic              cmpl_buf,
  input  logic [ASID_W-1:0] cmpl_asid,
  input  logic [ADDR_W-1:0] cmpl_pc,
  output logic              cmpl_ready,
  output logic [INSN_W-1:0] cmpl_insn,
  input  logic              sq_valid,
  input  logic [ASID_W-1:0] sq_asid,
  input  logic [ADDR_W-1:0] sq_pc
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int KEY_W  = ASID_W + TAG_W;
  localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int WSEL_W = OFF_W - 2;
  localparam int USED_W = $clog2(NUM_LINES + 1);

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [WSEL_W-1:0] word_sel(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:2];
  endfunction

  function automatic logic [INSN_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                  input logic [WSEL_W-1:0] s);
    return ln[s*INSN_W +: INSN_W];
  endfunction

  // in-flight list
  logic [NUM_LINES-1:0] p_vld, p_ok;
  logic [KEY_W-1:0]     p_key [NUM_LINES];
  logic [CNT_W-1:0]     p_cnt [NUM_LINES];
  logic [LINE_W-1:0]    p_dat [NUM_LINES];
  // resident set
  logic [NUM_LINES-1:0] r_vld;
  logic [KEY_W-1:0]     r_key [NUM_LINES];
  logic [CNT_W-1:0]     r_cnt [NUM_LINES];
  logic [LINE_W-1:0]    r_dat [NUM_LINES];
  logic [IDX_W-1:0]     age   [NUM_LINES];

  // operation slot
  ilb_op_e           op;
  logic [ASID_W-1:0] op_asid;
  logic [ADDR_W-1:0] op_pc;
  logic [KEY_W-1:0]  op_key, fill_key;

  always_comb begin
    op      = OP_NONE;
    op_asid = init_asid;
    op_pc   = init_pc;
    if (sq_valid) begin
      op = OP_SQSH; op_asid = sq_asid; op_pc = sq_pc;
    end else if (cmpl_valid) begin
      op = OP_CMPL; op_asid = cmpl_asid; op_pc = cmpl_pc;
    end else if (init_valid) begin
      op = OP_INIT;
    end
  end

  assign op_key   = {op_asid, line_tag(op_pc)};
  assign fill_key = {fill_asid, line_tag(fill_addr)};

  // flattened views and occupancy
  logic [NUM_LINES*KEY_W-1:0] p_keys, r_keys;
  logic [NUM_LINES*IDX_W-1:0] r_ages;
  logic [NUM_LINES-1:0]       r_idle, mru_vec;
  logic [USED_W-1:0]          pend_used, res_used;
  logic [IDX_W-1:0]           pf_idx;

  always_comb begin
    pend_used = '0;
    res_used  = '0;
    pf_idx    = '0;
    for (int j = 0; j < NUM_LINES; j++) begin
      p_keys[j*KEY_W +: KEY_W] = p_key[j];
      r_keys[j*KEY_W +: KEY_W] = r_key[j];
      r_ages[j*IDX_W +: IDX_W] = age[j];
      r_idle[j]  = (r_cnt[j] == '0);
      mru_vec[j] = (age[j] == IDX_W'(NUM_LINES - 1));
      pend_used  = pend_used + USED_W'(p_vld[j]);
      res_used   = res_used + USED_W'(r_vld[j]);
    end
    for (int j = NUM_LINES - 1; j >= 0; j--) begin
      if (!p_vld[j]) pf_idx = IDX_W'(j);
    end
  end

  logic             p_hit, r_hit, f_hit;
  logic [IDX_W-1:0] p_idx, r_idx, f_idx;
  logic             free_ok, evict_ok;
  logic [IDX_W-1:0] free_idx, evict_idx;

  ilb_match #(.N(NUM_LINES), .KEY_W(KEY_W)) u_pmatch (
    .vld(p_vld), .keys(p_keys), .key(op_key), .hit(p_hit), .idx(p_idx));
  ilb_match #(.N(NUM_LINES), .KEY_W(KEY_W)) u_rmatch (
    .vld(r_vld), .keys(r_keys), .key(op_key), .hit(r_hit), .idx(r_idx));
  ilb_match #(.N(NUM_LINES), .KEY_W(KEY_W)) u_fmatch (
    .vld(p_vld), .keys(p_keys), .key(fill_key), .hit(f_hit), .idx(f_idx));
  ilb_victim #(.N(NUM_LINES)) u_victim (
    .vld(r_vld), .idle(r_idle), .ages(r_ages),
    .free_ok(free_ok), .free_idx(free_idx),
    .evict_ok(evict_ok), .evict_idx(evict_idx));

  // named internal events
  logic             pfull, in_phit, in_rhit, in_sat, init_go;
  logic             room, cm_go, sq_res, sq_pend, fill_take;
  logic [IDX_W-1:0] dest;

  assign pfull   = (pend_used == USED_W'(NUM_LINES));
  assign in_phit = p_hit;
  assign in_rhit = !p_hit && !pfull && r_hit;
  assign in_sat  = (in_phit && (&p_cnt[p_idx])) || (in_rhit && (&r_cnt[r_idx]));
  assign init_go = (op == OP_INIT) && !in_sat && (in_phit || in_rhit || !pfull);

  assign init_ready = init_go;
  assign init_buf   = in_phit || in_rhit;
  assign lreq_valid = init_go && !(in_phit || in_rhit);
  assign lreq_asid  = init_asid;
  assign lreq_addr  = {line_tag(init_pc), {OFF_W{1'b0}}};

  assign room  = free_ok || evict_ok;
  assign dest  = free_ok ? free_idx : evict_idx;
  assign cm_go = (op == OP_CMPL) &&
                 (cmpl_buf ? r_hit : (p_hit && p_ok[p_idx] && room));
  assign cmpl_ready = cm_go;
  assign cmpl_insn  = pick_word(cmpl_buf ? r_dat[r_idx] : p_dat[p_idx], word_sel(cmpl_pc));

  assign sq_res    = (op == OP_SQSH) && r_hit;
  assign sq_pend   = (op == OP_SQSH) && !r_hit && p_hit;
  assign fill_take = fill_valid && f_hit && !p_ok[f_idx];

  logic [IDX_W-1:0] touch_idx;
  assign touch_idx = cmpl_buf ? r_idx : dest;

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (fill_take) p_dat[f_idx] <= fill_data;
    if (lreq_valid) p_key[pf_idx] <= op_key;
    if (cm_go && !cmpl_buf) begin
      r_key[dest] <= p_key[p_idx];
      r_dat[dest] <= p_dat[p_idx];
    end
  end

  // control state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld <= '0;
      p_ok  <= '0;
      r_vld <= '0;
      for (int j = 0; j < NUM_LINES; j++) begin
        p_cnt[j] <= '0;
        r_cnt[j] <= '0;
        age[j]   <= IDX_W'(j);
      end
    end else begin
      if (fill_take) p_ok[f_idx] <= 1'b1;
      if (lreq_valid) begin
        p_vld[pf_idx] <= 1'b1;
        p_ok[pf_idx]  <= 1'b0;
        p_cnt[pf_idx] <= CNT_W'(1);
      end
      if (init_go && in_phit) p_cnt[p_idx] <= p_cnt[p_idx] + 1'b1;
      if (init_go && in_rhit) r_cnt[r_idx] <= r_cnt[r_idx] + 1'b1;
      if (cm_go) begin
        if (cmpl_buf) begin
          r_cnt[r_idx] <= r_cnt[r_idx] - 1'b1;
        end else begin
          r_vld[dest]  <= 1'b1;
          r_cnt[dest]  <= p_cnt[p_idx] - 1'b1;
          p_vld[p_idx] <= 1'b0;
        end
        for (int j = 0; j < NUM_LINES; j++) begin
          if (IDX_W'(j) == touch_idx) age[j] <= IDX_W'(NUM_LINES - 1);
          else if (age[j] > age[touch_idx]) age[j] <= age[j] - 1'b1;
        end
      end
      if (sq_res && r_cnt[r_idx] != '0) r_cnt[r_idx] <= r_cnt[r_idx] - 1'b1;
      if (sq_pend) begin
        if (p_cnt[p_idx] <= CNT_W'(1)) p_vld[p_idx] <= 1'b0;
        else p_cnt[p_idx] <= p_cnt[p_idx] - 1'b1;
      end
    end
  end

  // R5
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_valid |-> pend_used < USED_W'(NUM_LINES));
  // R6
  lreq_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_valid |=> pend_used == USED_W'($past(pend_used) + 1'b1));
  // R8
  buf_hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_go && cmpl_buf) |=> res_used == $past(res_used));
  // R9
  fresh_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_go && !cmpl_buf) |=> pend_used == USED_W'($past(pend_used) - 1'b1));
  // R10
  mru_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mru_vec) == 1);
  // R11
  sq_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> pend_used <= $past(pend_used));
  // R12
  sq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> !init_ready && !cmpl_ready);
endmodule

// File: tb/ifetch_line_buf_bench.sv
module ifetch_line_buf_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         init_valid, init_buf, init_ready;
  logic [7:0]   init_asid;
  logic [31:0]  init_pc;
  logic         lreq_valid;
  logic [7:0]   lreq_asid;
  logic [31:0]  lreq_addr;
  logic         fill_valid;
  logic [7:0]   fill_asid;
  logic [31:0]  fill_addr;
  logic [511:0] fill_data;
  logic         cmpl_valid, cmpl_buf, cmpl_ready;
  logic [7:0]   cmpl_asid;
  logic [31:0]  cmpl_pc;
  logic [31:0]  cmpl_insn;
  logic         sq_valid;
  logic [7:0]   sq_asid;
  logic [31:0]  sq_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ifetch_line_buf u_ifetch_line_buf (
    .clk(clk), .rst_n(rst_n),
    .init_valid(init_valid), .init_asid(init_asid), .init_pc(init_pc),
    .init_ready(init_ready), .init_buf(init_buf),
    .lreq_valid(lreq_valid), .lreq_asid(lreq_asid), .lreq_addr(lreq_addr),
    .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_addr(fill_addr),
    .fill_data(fill_data),
    .cmpl_valid(cmpl_valid), .cmpl_buf(cmpl_buf), .cmpl_asid(cmpl_asid),
    .cmpl_pc(cmpl_pc), .cmpl_ready(cmpl_ready), .cmpl_insn(cmpl_insn),
    .sq_valid(sq_valid), .sq_asid(sq_asid), .sq_pc(sq_pc));

  // instruction word the bench places at a given PC
  function automatic logic [31:0] tb_word(input logic [7:0] a, input logic [31:0] pc);
    return {a, pc[23:2], 2'b01};
  endfunction

  function automatic logic [511:0] tb_line(input logic [7:0] a, input logic [31:0] base);
    logic [511:0] l;
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = tb_word(a, {base[31:6], 6'd0} + 32'(k * 4));
    return l;
  endfunction

  // vector: req, op (0 start, 1 finish, 2 line return, 3 squash), asid, pc, buf, rdy, flag, lreq
  function automatic logic [49:0] mk(input int req, input int op, input int a,
                                     input logic [31:0] pc, input bit b, input bit rdy,
                                     input bit flg, input bit lr);
    return {4'(req), 2'(op), 8'(a), pc, b, rdy, flg, lr};
  endfunction

  localparam int NV = 44;
  localparam logic [49:0] VEC [NV] = '{
    mk(6, 0, 1, 32'h1008, 0, 1, 0, 1),  // R6 first miss
    mk(3, 0, 1, 32'h100C, 0, 1, 1, 0),  // R3 joins in-flight
    mk(9, 1, 1, 32'h1008, 0, 0, 0, 0),  // R9 no data yet
    mk(7, 2, 1, 32'h1000, 0, 0, 0, 0),  // R7 line return
    mk(9, 1, 1, 32'h1008, 0, 1, 0, 0),  // R9 word 2
    mk(8, 1, 1, 32'h100C, 1, 1, 0, 0),  // R8 word 3
    mk(2, 0, 2, 32'h1000, 0, 1, 0, 1),  // R2 other asid misses
    mk(7, 2, 2, 32'h1000, 0, 0, 0, 0),
    mk(2, 1, 2, 32'h1000, 0, 1, 0, 0),  // R2 asid 2 word
    mk(4, 0, 1, 32'h103C, 0, 1, 1, 0),  // R4 resident hit
    mk(8, 1, 1, 32'h103C, 1, 1, 0, 0),  // R8 word 15
    mk(6, 0, 1, 32'h1040, 0, 1, 0, 1),
    mk(7, 2, 1, 32'h1040, 0, 0, 0, 0),
    mk(9, 1, 1, 32'h1040, 0, 1, 0, 0),
    mk(6, 0, 1, 32'h1080, 0, 1, 0, 1),
    mk(7, 2, 1, 32'h1080, 0, 0, 0, 0),
    mk(9, 1, 1, 32'h1088, 0, 1, 0, 0),
    mk(6, 0, 1, 32'h10C0, 0, 1, 0, 1),
    mk(7, 2, 1, 32'h10C0, 0, 0, 0, 0),
    mk(10, 1, 1, 32'h10C4, 0, 1, 0, 0), // R10 evicts LRU (asid 2 line)
    mk(10, 0, 2, 32'h1000, 0, 1, 0, 1), // R10 evicted line misses
    mk(10, 0, 1, 32'h1004, 0, 1, 1, 0), // R10 asid 1 line kept
    mk(4, 0, 1, 32'h1040, 0, 1, 1, 0),
    mk(4, 0, 1, 32'h1080, 0, 1, 1, 0),
    mk(4, 0, 1, 32'h10C0, 0, 1, 1, 0),
    mk(7, 2, 2, 32'h1000, 0, 0, 0, 0),
    mk(10, 1, 2, 32'h1000, 0, 0, 0, 0), // R10 all busy -> stall
    mk(11, 3, 1, 32'h1044, 0, 0, 0, 0), // R11 squash resident waiter
    mk(10, 1, 2, 32'h1008, 0, 1, 0, 0), // R10 now evicts idle line
    mk(10, 0, 1, 32'h1040, 0, 1, 0, 1), // R10 that line is gone
    mk(11, 3, 1, 32'h1040, 0, 0, 0, 0), // R11 drops in-flight entry
    mk(7, 2, 1, 32'h1040, 0, 0, 0, 0),  // R7 discarded return
    mk(11, 0, 1, 32'h1040, 0, 1, 0, 1), // R11 requested again
    mk(7, 1, 1, 32'h1040, 0, 0, 0, 0),  // R7 stale return not stored
    mk(7, 2, 1, 32'h1040, 0, 0, 0, 0),
    mk(9, 1, 1, 32'h1040, 0, 1, 0, 0),
    mk(6, 0, 1, 32'h2000, 0, 1, 0, 1),
    mk(6, 0, 1, 32'h2040, 0, 1, 0, 1),
    mk(6, 0, 1, 32'h2080, 0, 1, 0, 1),
    mk(6, 0, 1, 32'h20C0, 0, 1, 0, 1),
    mk(3, 0, 1, 32'h2004, 0, 1, 1, 0),  // R3 join while list full
    mk(5, 0, 1, 32'h1080, 0, 0, 0, 0),  // R5 resident but list full
    mk(5, 0, 1, 32'h3000, 0, 0, 0, 0),  // R5 new line, list full
    mk(11, 3, 1, 32'h2000, 0, 0, 0, 0)  // R11 squash one of two waiters
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    init_valid = 0; cmpl_valid = 0; fill_valid = 0; sq_valid = 0;
    cmpl_buf = 0;
  endtask

  task automatic set_init(input logic [7:0] a, input logic [31:0] pc);
    init_valid = 1; init_asid = a; init_pc = pc;
  endtask
  task automatic set_cmpl(input logic [7:0] a, input logic [31:0] pc, input bit b);
    cmpl_valid = 1; cmpl_asid = a; cmpl_pc = pc; cmpl_buf = b;
  endtask
  task automatic set_fill(input logic [7:0] a, input logic [31:0] pc);
    fill_valid = 1; fill_asid = a; fill_addr = pc; fill_data = tb_line(a, pc);
  endtask
  task automatic set_sq(input logic [7:0] a, input logic [31:0] pc);
    sq_valid = 1; sq_asid = a; sq_pc = pc;
  endtask

  task automatic chk_init(input int req, input logic [7:0] a, input logic [31:0] pc,
                          input bit rdy, input bit flg, input bit lr);
    chk(init_ready == rdy, req, "init_ready", 64'(init_ready), 64'(rdy));
    if (rdy) chk(init_buf == flg, req, "init_buf", 64'(init_buf), 64'(flg));
    chk(lreq_valid == lr, req, "lreq_valid", 64'(lreq_valid), 64'(lr));
    if (lr) chk(lreq_addr == {pc[31:6], 6'd0} && lreq_asid == a, req, "lreq_addr",
                64'(lreq_addr), 64'({pc[31:6], 6'd0}));
  endtask

  task automatic chk_cmpl(input int req, input logic [7:0] a, input logic [31:0] pc,
                          input bit rdy);
    chk(cmpl_ready == rdy, req, "cmpl_ready", 64'(cmpl_ready), 64'(rdy));
    if (rdy) chk(cmpl_insn == tb_word(a, pc), req, "cmpl_insn",
                 64'(cmpl_insn), 64'(tb_word(a, pc)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_in();
    init_asid = 0; init_pc = 0; cmpl_asid = 0; cmpl_pc = 0;
    fill_asid = 0; fill_addr = 0; fill_data = '0; sq_asid = 0; sq_pc = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state: nothing resident, no spurious outputs
    @(negedge clk); idle_in(); set_cmpl(8'd1, 32'h1000, 1'b1); #1;
    chk(init_ready == 0 && lreq_valid == 0, 1, "idle outputs", 64'(lreq_valid), 64'd0);
    chk_cmpl(1, 8'd1, 32'h1000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      int req, op;
      logic [7:0] a;
      logic [31:0] pc;
      v = VEC[i];
      req = int'(v[49:46]); op = int'(v[45:44]); a = v[43:36]; pc = v[35:4];
      @(negedge clk); idle_in();
      case (op)
        0: set_init(a, pc);
        1: set_cmpl(a, pc, v[3]);
        2: set_fill(a, pc);
        default: set_sq(a, pc);
      endcase
      #1;
      if (op == 0) chk_init(req, a, pc, v[2], v[1], v[0]);
      if (op == 1) chk_cmpl(req, a, pc, v[2]);
    end

    // R9: line return and finish for the same line in one cycle
    @(negedge clk); idle_in(); set_fill(8'd1, 32'h2040); set_cmpl(8'd1, 32'h2048, 1'b0); #1;
    chk_cmpl(9, 8'd1, 32'h2048, 1'b0);
    @(negedge clk); idle_in(); set_cmpl(8'd1, 32'h2048, 1'b0); #1;
    chk_cmpl(9, 8'd1, 32'h2048, 1'b1);

    // R12: squash beats start; squash took effect, start did not
    @(negedge clk); idle_in(); set_sq(8'd1, 32'h2080); set_init(8'd1, 32'h2008); #1;
    chk(init_ready == 0 && lreq_valid == 0, 12, "start under squash",
        64'(init_ready), 64'd0);
    @(negedge clk); idle_in(); set_init(8'd1, 32'h2080); #1;
    chk_init(11, 8'd1, 32'h2080, 1'b1, 1'b0, 1'b1);
    @(negedge clk); idle_in(); set_init(8'd1, 32'h2008); #1;
    chk_init(12, 8'd1, 32'h2008, 1'b1, 1'b1, 1'b0);

    // R12: finish beats start in the same cycle
    @(negedge clk); idle_in(); set_cmpl(8'd1, 32'h1084, 1'b1); set_init(8'd1, 32'h3000); #1;
    chk_cmpl(12, 8'd1, 32'h1084, 1'b1);
    chk(init_ready == 0, 12, "start under finish", 64'(init_ready), 64'd0);

    // R1: reset empties the resident set
    @(negedge clk); idle_in(); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk); idle_in(); set_init(8'd1, 32'h1080); #1;
    chk_init(1, 8'd1, 32'h1080, 1'b1, 1'b0, 1'b1);

    @(negedge clk); idle_in();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule